// File: doc/BRIEF.md
# Gather-Aware Descriptor Completion Engine

This block sits between a source descriptor queue and a pool of empty receive buffers. Each source descriptor names a buffer address, a 16-bit byte count and a 16-bit flag word. The engine merges any run of descriptors marked as gather, together with the descriptor that closes the run, into one transfer. That transfer fills exactly one posted destination buffer and raises exactly one completion. Data movement is modelled only as a sum of byte counts. No memory is read or written.

Empty destination buffers arrive on their own valid/ready stream and wait in a small in-order pool. The engine accepts source descriptors only while at least one buffer is waiting, so no descriptor is ever dropped. When a run closes, the engine emits a one-cycle completion record. The record carries the destination address, the total length, the transfer id and swap flag of the closing descriptor, an overflow flag for a saturated sum and an oversize flag for any descriptor above the configured limit. Outside the completion cycle the record length reads zero, which receivers treat as "not yet done".

Top module: `chain_merge_engine`

## Requirements
- R1: The flag word is decoded as: bit 0 is gather, bit 1 is byte swap, bits 15:4 are the transfer id. Bits 3:2 have no effect on any output.
- R2: A descriptor with gather clear that is not part of a run raises `cmp_valid` for one cycle, on the clock edge after its acceptance. The record holds the oldest posted buffer address and that descriptor's byte count.
- R3: Descriptors with gather set produce no completion. The descriptor that closes the run produces one completion whose length is the sum of every byte count in the run.
- R4: The completion's transfer id and swap flag are taken from the closing descriptor of the run, whatever the earlier descriptors carried.
- R5: `cmp_len` is zero in every cycle where `cmp_valid` is low, and is never zero while `cmp_valid` is high.
- R6: A run whose byte counts sum to zero produces no completion and consumes no buffer. The same buffer serves the next run.
- R7: The length sum saturates at 16'hFFFF. A saturated completion sets `cmp_ovf`, and the next run starts with `cmp_ovf` clear.
- R8: `cmp_oversize` is set when any descriptor of the run has a byte count strictly greater than `cfg_max_len`. A count equal to the limit does not set it.
- R9: `src_ready` is low whenever no posted buffer is waiting. A descriptor held on the input during such a stall is accepted later, unchanged.
- R10: Buffers are consumed in posting order. `dbuf_ready` is low when DBUF_DEPTH buffers are waiting. A post and a consumption in the same cycle both take effect.
- R11: During and right after reset, `cmp_valid` is 0, `cmp_len` is 0, `src_ready` is 0 and `dbuf_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_max_len | input | 16 | Largest byte count a single descriptor may carry without being flagged |
| src_valid | input | 1 | Source descriptor present |
| src_ready | output | 1 | Engine accepts the source descriptor |
| src_addr | input | 32 | Source buffer address |
| src_len | input | 16 | Source byte count |
| src_flags | input | 16 | Gather, swap and transfer id flags |
| dbuf_valid | input | 1 | Empty destination buffer offered |
| dbuf_ready | output | 1 | Buffer pool has room |
| dbuf_addr | input | 32 | Address of the offered buffer |
| cmp_valid | output | 1 | One-cycle completion pulse |
| cmp_addr | output | 32 | Destination buffer address of the completion |
| cmp_len | output | 16 | Total byte count, zero when no completion |
| cmp_tid | output | 12 | Transfer id of the closing descriptor |
| cmp_swap | output | 1 | Swap flag of the closing descriptor |
| cmp_ovf | output | 1 | Length sum saturated |
| cmp_oversize | output | 1 | A descriptor in the run exceeded the limit |

## Verification
A buffer post and a buffer consumption can happen in the same cycle. This happens when a closing descriptor is accepted while `dbuf_valid` is high. Directed steps provoke it with exactly one buffer waiting, and random stimulus provokes it again with about a third of cycles posting. Each case is judged by checking, every cycle, the pool occupancy implied by both ready outputs and the address order of the following completions against a bench queue model. A second overlap is a stall with buffers arriving. Here the bench checks that the held descriptor is accepted one cycle after the first post, not in the posting cycle.

// File: rtl/cme_pkg.sv
package cme_pkg;
  // Flag word field positions; the engine decodes these.
  parameter int unsigned GATHER_POS = 0;
  parameter int unsigned SWAP_POS   = 1;
  parameter int unsigned TID_LSB    = 4;
endpackage

// File: rtl/cme_buf_pool.sv
module cme_buf_pool #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic              not_empty,
  output logic              full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] slot_q [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wen;
    assign wen = push && (wr_q == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (wen) slot_q[g] <= push_addr;
    end
  end

  assign head_addr = slot_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CW'(DEPTH));

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
endmodule

// File: rtl/cme_chain_accum.sv
module cme_chain_accum #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             last,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] sum_next,
  output logic             ovf_next,
  output logic             big_next
);
  logic [LEN_W-1:0] acc_q, acc_d;
  logic             ovf_q, ovf_d, big_q, big_d;
  logic [LEN_W:0]   wide;

  always_comb begin
    wide     = {1'b0, acc_q} + {1'b0, len};
    sum_next = wide[LEN_W] ? '1 : wide[LEN_W-1:0];
    ovf_next = ovf_q | wide[LEN_W];
    big_next = big_q | (len > max_len);
    acc_d = acc_q;
    ovf_d = ovf_q;
    big_d = big_q;
    if (take) begin
      acc_d = last ? '0   : sum_next;
      ovf_d = last ? 1'b0 : ovf_next;
      big_d = last ? 1'b0 : big_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      big_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
      big_q <= big_d;
    end
  end

  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (acc_q == '1));
  assert_stall_keeps_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(acc_q));
endmodule

// File: rtl/chain_merge_engine.sv
module chain_merge_engine #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned FLG_W      = 16,
  parameter int unsigned DBUF_DEPTH = 4,
  localparam int unsigned TID_W     = FLG_W - cme_pkg::TID_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [LEN_W-1:0]  src_len,
  input  logic [FLG_W-1:0]  src_flags,
  input  logic              dbuf_valid,
  output logic              dbuf_ready,
  input  logic [ADDR_W-1:0] dbuf_addr,
  output logic              cmp_valid,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic [LEN_W-1:0]  cmp_len,
  output logic [TID_W-1:0]  cmp_tid,
  output logic              cmp_swap,
  output logic              cmp_ovf,
  output logic              cmp_oversize
);
  import cme_pkg::*;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic              buf_avail, buf_full, dbuf_take, take, is_last, publish;
  logic [ADDR_W-1:0] head_addr;
  logic [LEN_W-1:0]  sum_next;
  logic              ovf_next, big_next;
  logic              src_addr_unused;

  assign src_addr_unused = ^src_addr; // address only names data, which is not moved
  assign src_ready = buf_avail;
  assign dbuf_ready = !buf_full;
  assign dbuf_take = dbuf_valid && dbuf_ready;
  assign take      = src_valid && src_ready;
  assign is_last   = !src_flags[GATHER_POS];
  assign publish   = take && is_last && (sum_next != '0);

  cme_buf_pool #(.ADDR_W(ADDR_W), .DEPTH(DBUF_DEPTH)) u_pool (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push      (dbuf_take),
    .push_addr (dbuf_addr),
    .pop       (publish),
    .head_addr (head_addr),
    .not_empty (buf_avail),
    .full      (buf_full)
  );

  cme_chain_accum #(.LEN_W(LEN_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .take     (take),
    .last     (is_last),
    .len      (src_len),
    .max_len  (cfg_max_len),
    .sum_next (sum_next),
    .ovf_next (ovf_next),
    .big_next (big_next)
  );

  // Completion record: next-state and register processes.
  logic              v_d;
  logic [ADDR_W-1:0] a_d;
  logic [LEN_W-1:0]  l_d;
  logic [TID_W-1:0]  t_d;
  logic              s_d, o_d, b_d;

  always_comb begin
    v_d = publish;
    a_d = '0;
    l_d = '0;
    t_d = '0;
    s_d = 1'b0;
    o_d = 1'b0;
    b_d = 1'b0;
    if (publish) begin
      a_d = head_addr;
      l_d = sum_next;
      t_d = src_flags[FLG_W-1:TID_LSB];
      s_d = src_flags[SWAP_POS];
      o_d = ovf_next;
      b_d = big_next;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmp_valid    <= 1'b0;
      cmp_addr     <= '0;
      cmp_len      <= '0;
      cmp_tid      <= '0;
      cmp_swap     <= 1'b0;
      cmp_ovf      <= 1'b0;
      cmp_oversize <= 1'b0;
    end else begin
      cmp_valid    <= v_d;
      cmp_addr     <= a_d;
      cmp_len      <= l_d;
      cmp_tid      <= t_d;
      cmp_swap     <= s_d;
      cmp_ovf      <= o_d;
      cmp_oversize <= b_d;
    end
  end

  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmp_valid |-> (cmp_len != '0));
  assert_len_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cmp_valid |-> (cmp_len == '0));
  assert_stall_no_done_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (src_valid && !src_ready) |=> !cmp_valid);
  assert_gather_quiet_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (src_valid && src_flags[GATHER_POS]) |=> !cmp_valid);
endmodule

// File: tb/sim_chain_merge_engine.sv
`timescale 1ns/1ps
module sim_chain_merge_engine;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] cfg_max_len;
  logic        src_valid, src_ready, dbuf_valid, dbuf_ready;
  logic [31:0] src_addr, dbuf_addr, cmp_addr;
  logic [15:0] src_len, src_flags, cmp_len;
  logic        cmp_valid, cmp_swap, cmp_ovf, cmp_oversize;
  logic [11:0] cmp_tid;

  chain_merge_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_max_len(cfg_max_len),
    .src_valid(src_valid), .src_ready(src_ready), .src_addr(src_addr),
    .src_len(src_len), .src_flags(src_flags),
    .dbuf_valid(dbuf_valid), .dbuf_ready(dbuf_ready), .dbuf_addr(dbuf_addr),
    .cmp_valid(cmp_valid), .cmp_addr(cmp_addr), .cmp_len(cmp_len),
    .cmp_tid(cmp_tid), .cmp_swap(cmp_swap), .cmp_ovf(cmp_ovf),
    .cmp_oversize(cmp_oversize)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Bench model
  logic [31:0] pool[$];
  logic [15:0] m_acc = 16'h0;
  bit          m_ovf = 0, m_big = 0;
  bit          e_v;
  logic [31:0] e_a;
  logic [15:0] e_l;
  logic [11:0] e_t;
  bit          e_s, e_o, e_b;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] add_sat(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] w;
    w = {1'b0, a} + {1'b0, b};
    return w[16] ? {1'b1, 16'hFFFF} : w;
  endfunction

  task automatic step(input bit sv, input logic [15:0] sl, input logic [15:0] sf,
                      input bit dv, input logic [31:0] da, input string tag);
    bit rdy, drdy, tk, dtk;
    logic [16:0] r;
    @(negedge clk);
    src_valid = sv; src_addr = $urandom; src_len = sl; src_flags = sf;
    dbuf_valid = dv; dbuf_addr = da;
    #1;
    rdy  = (pool.size() > 0);
    drdy = (pool.size() < DEPTH);
    chk(src_ready === rdy, "R9", "src_ready", 32'(src_ready), 32'(rdy));
    chk(dbuf_ready === drdy, "R10", "dbuf_ready", 32'(dbuf_ready), 32'(drdy));
    tk = sv && rdy;
    dtk = dv && drdy;
    e_v = 0; e_a = 0; e_l = 0; e_t = 0; e_s = 0; e_o = 0; e_b = 0;
    if (tk) begin
      r = add_sat(m_acc, sl);
      if (sf[0]) begin
        m_acc = r[15:0]; m_ovf = m_ovf | r[16]; m_big = m_big | (sl > cfg_max_len);
      end else begin
        if (r[15:0] != 0) begin
          e_v = 1; e_a = pool.pop_front(); e_l = r[15:0]; e_t = sf[15:4];
          e_s = sf[1]; e_o = m_ovf | r[16]; e_b = m_big | (sl > cfg_max_len);
        end
        m_acc = 0; m_ovf = 0; m_big = 0;
      end
    end
    if (dtk) pool.push_back(da);
    @(posedge clk);
    #1;
    chk(cmp_valid === e_v, tag, "cmp_valid", 32'(cmp_valid), 32'(e_v));
    if (e_v) begin
      chk(cmp_addr === e_a, "R10", "cmp_addr", cmp_addr, e_a);
      chk(cmp_len === e_l, "R3", "cmp_len", 32'(cmp_len), 32'(e_l));
      chk(cmp_tid === e_t, "R4", "cmp_tid", 32'(cmp_tid), 32'(e_t));
      chk(cmp_swap === e_s, "R4", "cmp_swap", 32'(cmp_swap), 32'(e_s));
      chk(cmp_ovf === e_o, "R7", "cmp_ovf", 32'(cmp_ovf), 32'(e_o));
      chk(cmp_oversize === e_b, "R8", "cmp_oversize", 32'(cmp_oversize), 32'(e_b));
    end else begin
      chk(cmp_len === 16'h0, "R5", "idle cmp_len", 32'(cmp_len), 32'h0);
    end
  endtask

  function automatic logic [15:0] fl(input bit g, input bit s, input logic [11:0] t);
    return {t, 2'b00, s, g};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    cfg_max_len = 16'd1000;
    src_valid = 0; src_addr = 0; src_len = 0; src_flags = 0;
    dbuf_valid = 0; dbuf_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(cmp_valid === 1'b0, "R11", "cmp_valid", 32'(cmp_valid), 0);
    chk(cmp_len === 16'h0, "R11", "cmp_len", 32'(cmp_len), 0);
    chk(src_ready === 1'b0, "R11", "src_ready", 32'(src_ready), 0);
    chk(dbuf_ready === 1'b1, "R11", "dbuf_ready", 32'(dbuf_ready), 1);

    // R9 stall with no buffer, then buffer arrives while descriptor held
    repeat (3) step(1, 16'd40, fl(0, 0, 12'h011), 0, 0, "R9");
    step(1, 16'd40, fl(0, 0, 12'h011), 1, 32'hB000_0001, "R9");
    step(1, 16'd40, fl(0, 0, 12'h011), 0, 0, "R9");
    step(0, 0, 0, 0, 0, "R9");

    // R10 fill the pool to full, then post while full
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 32'hB100_0000 + i, "R10");

    // R2 single descriptor
    step(1, 16'd100, fl(0, 1, 12'h005), 0, 0, "R2");
    // R3/R4 three-part chain, earlier parts carry other tid/swap
    step(1, 16'd10, fl(1, 1, 12'hAAA), 0, 0, "R3");
    step(1, 16'd20, fl(1, 1, 12'hBBB), 0, 0, "R3");
    step(1, 16'd30, fl(0, 0, 12'h007), 0, 0, "R4");
    // R1 reserved bits 3:2 set
    step(1, 16'd9, 16'h123C, 0, 0, "R1");
    step(1, 16'd9, 16'h123D, 0, 0, "R1");
    step(1, 16'd1, 16'h4560 | 16'h000C, 1, 32'hB200_0000, "R1");
    // R7 saturation, then fresh run
    step(1, 16'hF000, fl(1, 0, 12'h001), 0, 0, "R7");
    step(1, 16'h2000, fl(1, 0, 12'h002), 0, 0, "R7");
    step(1, 16'h0000, fl(0, 0, 12'h003), 0, 0, "R7");
    step(1, 16'd5, fl(0, 0, 12'h004), 1, 32'hB200_0001, "R7");
    // R6 zero-sum run keeps buffer
    step(1, 16'd0, fl(1, 0, 12'h0F0), 0, 0, "R6");
    step(1, 16'd0, fl(0, 0, 12'h0F1), 0, 0, "R6");
    step(1, 16'd77, fl(0, 0, 12'h0F2), 0, 0, "R6");
    // R8 limit boundary
    cfg_max_len = 16'd50;
    step(1, 16'd50, fl(0, 0, 12'h0E0), 1, 32'hB300_0000, "R8");
    step(1, 16'd51, fl(1, 0, 12'h0E1), 1, 32'hB300_0001, "R8");
    step(1, 16'd2, fl(0, 0, 12'h0E2), 1, 32'hB300_0002, "R8");
    step(1, 16'd3, fl(0, 0, 12'h0E3), 0, 0, "R8");
    // drain to one buffer, then simultaneous post and consume (R10)
    while (pool.size() > 1) step(1, 16'd4, fl(0, 0, 12'h0D0), 0, 0, "R10");
    step(1, 16'd6, fl(0, 0, 12'h0D1), 1, 32'hB400_0000, "R10");
    step(1, 16'd7, fl(0, 0, 12'h0D2), 0, 0, "R10");
    step(1, 16'd8, fl(0, 0, 12'h0D3), 0, 0, "R10");

    // Constrained random traffic
    cfg_max_len = 16'd150;
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] l;
      int pick;
      pick = $urandom % 32;
      if (pick == 0)      l = 16'h8000 + 16'($urandom % 16'h7000);
      else if (pick < 3)  l = 0;
      else                l = 16'($urandom % 200);
      step(($urandom % 4) != 0, l,
           fl(($urandom % 3) == 0, $urandom % 2, 12'($urandom)) | 16'(($urandom % 4) << 2),
           ($urandom % 3) == 0, $urandom, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule